// File: doc/BRIEF.md
# Write Buffer with Read Bypass

The block sits between a cache and main memory and holds a few pending memory writes. Dirty blocks evicted by a write-back cache and stores from a write-through cache are both parked here. The cache therefore completes its writes at its own speed. The parked writes go out to memory one at a time, oldest first, whenever the memory port is not needed for a read.

A read miss from the cache is first compared against every pending write. When the address is found, the newest buffered data is returned to the cache one cycle later and memory is not read. When the address is not found, the read goes to memory at once, ahead of all queued writes. The read never waits for the buffer to empty.

A write to an address that is already buffered updates that entry instead of taking a new slot. The one exception is the entry currently offered to memory, which is left unchanged. In that case the write takes a fresh slot, and the newest copy wins on lookup.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the buffer is empty: `wr_ready_o` and `rd_ready_o` are high, and `mem_req_valid_o` and `rsp_valid_o` are low.
- R2: A write is taken when `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` is low exactly when all DEPTH slots are occupied, even if the offered address is already buffered, and stays low until an entry drains.
- R3: A taken write whose address matches a pending entry, other than the head entry currently offered to memory, overwrites that entry's data and uses no new slot.
- R4: While a buffered write is offered to memory (`mem_req_valid_o`=1, `mem_req_we_o`=1) and not accepted, its address and data stay unchanged, even when the cache writes the same address again.
- R5: Buffered writes reach memory with `mem_req_we_o`=1 in the order their slots were allocated. Each carries the latest data merged into it, so memory ends up holding the program-order final value of every address.
- R6: No buffered write is offered to memory in a cycle where `rd_valid_i` is high, or while a read miss is outstanding.
- R7: A read taken (`rd_valid_i` and `rd_ready_o` high) whose address matches buffered entries returns the data of the youngest matching entry on `rsp_data_o`, with `rsp_valid_o` high in the next cycle. No memory read is issued for it.
- R8: A read that matches no entry issues a memory read (`mem_req_we_o`=0) in the next cycle, before any queued write. The request is held until `mem_req_ready_i`, and the response follows one cycle after `mem_rsp_valid_i` and carries `mem_rsp_data_i`.
- R9: When a read and a write to the same address are taken in the same cycle, the read observes the buffer as it was before that write.
- R10: `rd_ready_o` is low from the cycle after a missing read is taken until its response cycle, so at most one memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Cache offers a write |
| wr_ready_o | output | 1 | Buffer has a free slot |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| rd_valid_i | input | 1 | Cache read miss request |
| rd_ready_o | output | 1 | Read lookup can take a request |
| rd_addr_i | input | AW | Read miss address |
| rsp_valid_o | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data_o | output | DW | Read data |
| mem_req_valid_o | output | 1 | Memory command valid |
| mem_req_ready_i | input | 1 | Memory accepts command |
| mem_req_we_o | output | 1 | 1 = write command, 0 = read command |
| mem_req_addr_o | output | AW | Memory command address |
| mem_req_wdata_o | output | DW | Memory write data |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_data_i | input | DW | Memory read data |

## Verification
The assertions assume that memory raises `mem_rsp_valid_i` only to answer a read it has accepted, exactly once, and never for writes. They also assume the cache holds nothing in flight that the buffer does not see. The bench memory model tracks the single outstanding read it accepted and answers it after one to three cycles. It drives the response strobe at no other time. Random traffic is confined to a handful of addresses, so merges, duplicate entries and lookup hits happen often. Directed sequences hold the memory port off to fill the buffer and to force a read miss ahead of the queued writes.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_WAIT  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          head_lock_i,
  input  logic          pop_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic          look_hit_o,
  output logic [DW-1:0] look_data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;

  logic             merge_hit;
  logic [PW-1:0]    merge_idx;
  logic             push_new;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // walk entries oldest to youngest; later matches override earlier ones
  always_comb begin
    logic [PW-1:0] j;
    look_hit_o  = 1'b0;
    look_data_o = '0;
    merge_hit   = 1'b0;
    merge_idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      j = PW'((int'(head_q) + k) % DEPTH);
      if (vld_q[j] && addr_q[j] == look_addr_i) begin
        look_hit_o  = 1'b1;
        look_data_o = data_q[j];
      end
      if (vld_q[j] && addr_q[j] == push_addr_i && !(k == 0 && head_lock_i)) begin
        merge_hit = 1'b1;
        merge_idx = j;
      end
    end
  end

  assign push_new    = push_i && !merge_hit;
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
    end else begin
      if (pop_i) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= ptr_inc(head_q);
      end
      if (push_new) begin
        vld_q[tail_q] <= 1'b1;
        tail_q        <= ptr_inc(tail_q);
      end
      cnt_q <= cnt_q + CW'(push_new) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      if (merge_hit) begin
        data_q[merge_idx] <= push_data_i;
      end else begin
        addr_q[tail_q] <= push_addr_i;
        data_q[tail_q] <= push_data_i;
      end
    end
  end
endmodule

// File: rtl/wbuf_rd_ctrl.sv
module wbuf_rd_ctrl
  import wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_ready_o,
  input  logic          look_hit_i,
  input  logic [DW-1:0] look_data_i,
  output logic          mreq_valid_o,
  output logic [AW-1:0] mreq_addr_o,
  input  logic          mreq_ready_i,
  input  logic          mrsp_valid_i,
  input  logic [DW-1:0] mrsp_data_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  rd_state_e     state_q;
  logic [AW-1:0] addr_q;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RD_IDLE;
      addr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        RD_IDLE: if (rd_valid_i) begin
          if (look_hit_i) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= look_data_i;
          end else begin
            addr_q  <= rd_addr_i;
            state_q <= RD_ISSUE;
          end
        end
        RD_ISSUE: if (mreq_ready_i) state_q <= RD_WAIT;
        RD_WAIT: if (mrsp_valid_i) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= mrsp_data_i;
          state_q     <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign rd_ready_o   = (state_q == RD_IDLE);
  assign mreq_valid_o = (state_q == RD_ISSUE);
  assign mreq_addr_o  = addr_q;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_data_o   = rsp_data_q;
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_valid_i,
  output logic          rd_ready_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i
);
  logic          full, empty, push, pop, drain_valid;
  logic [AW-1:0] head_addr, rd_maddr;
  logic [DW-1:0] head_data, look_data;
  logic          look_hit, rd_mvalid;

  assign push        = wr_valid_i && !full;
  assign wr_ready_o  = !full;
  // reads own the memory port from request until response
  assign drain_valid = !empty && rd_ready_o && !rd_valid_i;
  assign pop         = drain_valid && mem_req_ready_i;

  wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (wr_addr_i),
    .push_data_i (wr_data_i),
    .head_lock_i (drain_valid),
    .pop_i       (pop),
    .look_addr_i (rd_addr_i),
    .full_o      (full),
    .empty_o     (empty),
    .head_addr_o (head_addr),
    .head_data_o (head_data),
    .look_hit_o  (look_hit),
    .look_data_o (look_data)
  );

  wbuf_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_valid_i   (rd_valid_i),
    .rd_addr_i    (rd_addr_i),
    .rd_ready_o   (rd_ready_o),
    .look_hit_i   (look_hit),
    .look_data_i  (look_data),
    .mreq_valid_o (rd_mvalid),
    .mreq_addr_o  (rd_maddr),
    .mreq_ready_i (mem_req_ready_i),
    .mrsp_valid_i (mem_rsp_valid_i),
    .mrsp_data_i  (mem_rsp_data_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_data_o   (rsp_data_o)
  );

  assign mem_req_valid_o = rd_mvalid || drain_valid;
  assign mem_req_we_o    = drain_valid;
  assign mem_req_addr_o  = rd_mvalid ? rd_maddr : head_addr;
  assign mem_req_wdata_o = head_data;
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_ready_o,
  input logic          rd_valid_i,
  input logic          rd_ready_o,
  input logic          rsp_valid_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic          mem_req_we_o,
  input logic [AW-1:0] mem_req_addr_o,
  input logic [DW-1:0] mem_req_wdata_o,
  input logic          mem_rsp_valid_i
);
  p_full_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o && !(mem_req_valid_o && mem_req_we_o && mem_req_ready_i) |=> !wr_ready_o);

  p_wr_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_we_o && !mem_req_ready_i |=>
      !(mem_req_valid_o && mem_req_we_o) ||
      ($stable(mem_req_addr_o) && $stable(mem_req_wdata_o)));

  p_no_drain_on_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i || !rd_ready_o |-> !(mem_req_valid_o && mem_req_we_o));

  p_rsp_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(rd_valid_i && rd_ready_o) || $past(mem_rsp_valid_i));

  p_rdreq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_we_o && !mem_req_ready_i |=>
      mem_req_valid_o && !mem_req_we_o && $stable(mem_req_addr_o));

  p_one_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_we_o |-> !rd_ready_o);
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_ready_o      (wr_ready_o),
  .rd_valid_i      (rd_valid_i),
  .rd_ready_o      (rd_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_we_o    (mem_req_we_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_wdata_o (mem_req_wdata_o),
  .mem_rsp_valid_i (mem_rsp_valid_i)
);

// File: tb/wbuf_bypass_test.sv
module wbuf_bypass_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni;
  logic wr_valid_i, wr_ready_o, rd_valid_i, rd_ready_o, rsp_valid_o;
  logic [AW-1:0] wr_addr_i, rd_addr_i, mem_req_addr_o;
  logic [DW-1:0] wr_data_i, rsp_data_o, mem_req_wdata_o, mem_rsp_data_i;
  logic mem_req_valid_o, mem_req_ready_i, mem_req_we_o, mem_rsp_valid_i;

  wbuf_bypass #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_valid_i(rd_valid_i), .rd_ready_o(rd_ready_o), .rd_addr_i(rd_addr_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i), .mem_req_we_o(mem_req_we_o),
    .mem_req_addr_o(mem_req_addr_o), .mem_req_wdata_o(mem_req_wdata_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i)
  );

  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  logic [DW-1:0] exp_q [$];
  logic [AW-1:0] wlog_a [$];
  logic [DW-1:0] wlog_d [$];
  int n_tests = 0, n_fail = 0;
  int lat = 0, first_kind = -1, r6_bad = 0, rdreq_seen = 0;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] last_rsp;
  bit track_first = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: inputs already set at negedge; observe before posedge
  task automatic step();
    #1;
    if (rsp_valid_o) begin
      last_rsp = rsp_data_o;
      if (exp_q.size() == 0) check(1'b0, "R7 R8", "response with no read", int'(rsp_data_o), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rsp_data_o == e, "R7 R8", "read data", int'(rsp_data_o), int'(e));
      end
    end
    if ((rd_valid_i || !rd_ready_o) && mem_req_valid_o && mem_req_we_o) r6_bad++;
    if (mem_req_valid_o && !mem_req_we_o) rdreq_seen++;
    if (rd_valid_i && rd_ready_o) exp_q.push_back(shadow[rd_addr_i]);
    if (wr_valid_i && wr_ready_o) shadow[wr_addr_i] = wr_data_i;
    if (mem_req_valid_o && mem_req_ready_i) begin
      if (track_first && first_kind < 0) first_kind = mem_req_we_o ? 1 : 0;
      if (mem_req_we_o) begin
        mem[mem_req_addr_o] = mem_req_wdata_o;
        wlog_a.push_back(mem_req_addr_o);
        wlog_d.push_back(mem_req_wdata_o);
      end else begin
        lat = 1 + int'($urandom % 3);
        lat_addr = mem_req_addr_o;
      end
    end
    @(negedge clk);
    mem_rsp_valid_i = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i = mem[lat_addr];
      end
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    step();
    wr_valid_i = 1'b0;
  endtask

  initial begin
    #800000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      mem[i] = DW'(i * 37 + 5);
      shadow[i] = mem[i];
    end
    rst_ni = 1'b0;
    wr_valid_i = 0; wr_addr_i = 0; wr_data_i = 0;
    rd_valid_i = 0; rd_addr_i = 0;
    mem_req_ready_i = 0; mem_rsp_valid_i = 0; mem_rsp_data_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(wr_ready_o == 1'b1, "R1", "wr_ready after reset", int'(wr_ready_o), 1);
    check(rd_ready_o == 1'b1, "R1", "rd_ready after reset", int'(rd_ready_o), 1);
    check(mem_req_valid_o == 1'b0, "R1", "mem_req_valid after reset", int'(mem_req_valid_o), 0);
    check(rsp_valid_o == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid_o), 0);
    @(negedge clk);

    // fill with memory stalled: A, B x3 (merge), C
    wr(8'h10, 16'h1111); wr(8'h20, 16'h2222); wr(8'h20, 16'h2223);
    wr(8'h20, 16'h2224); wr(8'h30, 16'h3333);
    check(wr_ready_o == 1'b1, "R3", "merged writes share a slot", int'(wr_ready_o), 1);
    wr(8'h40, 16'h4444);
    check(wr_ready_o == 1'b0, "R2", "ready low when full", int'(wr_ready_o), 0);
    wr(8'h20, 16'h5555);
    check(wr_ready_o == 1'b0, "R2", "full rejects matching write", int'(wr_ready_o), 0);
    check(mem_req_addr_o == 8'h10, "R4", "head address held", int'(mem_req_addr_o), 'h10);
    check(mem_req_wdata_o == 16'h1111, "R4", "head data held", int'(mem_req_wdata_o), 'h1111);

    // hit forwarding
    rdreq_seen = 0;
    rd_valid_i = 1'b1; rd_addr_i = 8'h20;
    step();
    rd_valid_i = 1'b0;
    step();
    check(last_rsp == 16'h2224, "R7", "youngest merged data forwarded", int'(last_rsp), 'h2224);
    check(rdreq_seen == 0, "R7", "no memory read on hit", rdreq_seen, 0);
    check(exp_q.size() == 0, "R7", "hit answered next cycle", exp_q.size(), 0);

    // miss bypasses queued writes
    wlog_a.delete(); wlog_d.delete();
    track_first = 1; first_kind = -1;
    rd_valid_i = 1'b1; rd_addr_i = 8'h60;
    step();
    rd_valid_i = 1'b0;
    check(rd_ready_o == 1'b0, "R10", "lookup busy during miss", int'(rd_ready_o), 0);
    mem_req_ready_i = 1'b1;
    repeat (14) step();
    track_first = 0;
    check(first_kind == 0, "R8", "read ahead of writes", first_kind, 0);
    check(exp_q.size() == 0, "R8", "miss answered", exp_q.size(), 0);
    check(wlog_a.size() == 4, "R5", "drain count", wlog_a.size(), 4);
    if (wlog_a.size() == 4) begin
      check(wlog_a[0] == 8'h10 && wlog_d[0] == 16'h1111, "R5", "drain 0", int'(wlog_a[0]), 'h10);
      check(wlog_a[1] == 8'h20 && wlog_d[1] == 16'h2224, "R5", "drain 1", int'(wlog_d[1]), 'h2224);
      check(wlog_a[2] == 8'h30 && wlog_d[2] == 16'h3333, "R5", "drain 2", int'(wlog_a[2]), 'h30);
      check(wlog_a[3] == 8'h40 && wlog_d[3] == 16'h4444, "R5", "drain 3", int'(wlog_a[3]), 'h40);
    end
    check(wr_ready_o == 1'b1, "R2", "ready back after drain", int'(wr_ready_o), 1);

    // duplicate behind a locked head, read and write same cycle
    mem_req_ready_i = 1'b0;
    wr(8'h70, 16'h00A0);
    wr(8'h70, 16'h00A1);
    rd_valid_i = 1'b1; rd_addr_i = 8'h70;
    wr_valid_i = 1'b1; wr_addr_i = 8'h70; wr_data_i = 16'h00A2;
    step();
    rd_valid_i = 1'b0; wr_valid_i = 1'b0;
    step();
    check(last_rsp == 16'h00A1, "R9", "read sees buffer before same-cycle write", int'(last_rsp), 'hA1);
    wlog_a.delete(); wlog_d.delete();
    mem_req_ready_i = 1'b1;
    repeat (6) step();
    check(wlog_a.size() == 2, "R3", "duplicate entries drain separately", wlog_a.size(), 2);
    if (wlog_a.size() == 2) begin
      check(wlog_d[0] == 16'h00A0, "R4", "locked head kept its data", int'(wlog_d[0]), 'hA0);
      check(wlog_d[1] == 16'h00A2, "R3", "merge into youngest copy", int'(wlog_d[1]), 'hA2);
    end

    // random traffic on a small address set
    for (int c = 0; c < 3000; c++) begin
      wr_valid_i = 1'($urandom % 2);
      wr_addr_i = AW'(8'h80 + 4 * ($urandom % 6));
      wr_data_i = DW'($urandom);
      rd_valid_i = ($urandom % 4) == 0;
      rd_addr_i = AW'(8'h80 + 4 * ($urandom % 6));
      mem_req_ready_i = ($urandom % 3) != 0;
      step();
    end
    wr_valid_i = 0; rd_valid_i = 0; mem_req_ready_i = 1'b1;
    repeat (30) step();
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
      check(bad == 0, "R5", "memory matches program order", bad, 0);
    end
    check(exp_q.size() == 0, "R8", "all reads answered", exp_q.size(), 0);
    check(r6_bad == 0, "R6", "no write offered during read", r6_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule